// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width modulator. A 16-bit counter steps at a rate set by a two-stage clock prescaler. It counts up, down or up-down against a programmable period, or it holds still. Downstream compare and output-shaping logic consume the live count, a direction flag and two one-cycle strobes. One strobe marks the counter landing on zero and the other marks it landing on the active period.

Software programs the block through a simple write port. It writes a 16-bit control word and a 16-bit period word. The period can be applied at once or staged in a holding register that takes effect at the next zero landing, which keeps waveforms glitch-free. Run control can halt the counter at once, let it finish its current cycle down to zero, or leave it running freely. The prescaler produces a clock-enable pulse and never gates the clock.

Top module: `pwm_timebase`

## Requirements
- R1: A write with `wr_addr` = 0x00 loads the control word and `wr_addr` = 0x0A loads the period word. Writes to any other address have no effect. After reset the control word, the active period, the staged period and the count are 0, `dir_up` is 1, and both strobes are 0.
- R2: The counter steps at most once every D clock cycles. D = 2^C × H, where C is control bits 12:10 and H is 1 when control bits 9:7 are zero and twice their value otherwise.
- R3: A control write that changes any of bits 12:7 restarts the prescale count. The first step under the new divider happens D cycles after the writing edge.
- R4: With control bits 1:0 = 00 (up), each step goes from count to count+1, or to 0 when the count is at or above the active period.
- R5: With bits 1:0 = 01 (down), each step goes from count to count−1, or from 0 to the active period.
- R6: With bits 1:0 = 10 (up-down), the counter rises to the active period and then falls to 0, reversing at each end; with a period of 0 it stays at 0. `dir_up` shows the direction of the most recent step: 1 in up mode and 0 in down mode.
- R7: With bits 1:0 = 11 the count, `dir_up` and the strobes stay frozen (the strobes read 0).
- R8: Control bits 15:14 set run control. 00 allows no steps. 01 allows steps only while the count is non-zero, so the counter stops once it reaches 0. 10 and 11 allow free running.
- R9: When control bit 3 is 1, a period write updates the active period at once. When bit 3 is 0, the write goes to the staged period, which is copied to the active period on every step that lands on 0.
- R10: `zero_stb` is high for the one cycle after a step that lands on 0. `prd_stb` is high for the one cycle after a step that lands on the active period in force at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_out | output | 16 | Current counter value |
| dir_up | output | 1 | Direction of the most recent step (1 = up) |
| zero_stb | output | 1 | One-cycle strobe after landing on zero |
| prd_stb | output | 1 | One-cycle strobe after landing on the active period |

## Verification
A wrong prescale phase or divider shows on `cnt_out` within one divider interval: a step arrives a cycle early or late relative to the write that set the divider. A corrupted active or staged period appears only at the next reversal or wrap, up to a full counter cycle later, as a wrong peak value or a misplaced `prd_stb`. Direction or run-state errors show on the very next step as a count moving the wrong way, or moving when it should hold. The bench runs a cycle-by-cycle reference model alongside the design, so any of these becomes visible on the first cycle where the ports differ.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int CTRL_W = 16;

  // control word field positions (decoded by this block)
  localparam int MODE_LSB = 0;
  localparam int PLD_BIT  = 3;
  localparam int HS_LSB   = 7;
  localparam int CK_LSB   = 10;
  localparam int RUN_LSB  = 14;
  localparam int DIV_MSB  = 12;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    RUN_HALT   = 2'b00,
    RUN_ENDCYC = 2'b01,
    RUN_FREE_A = 2'b10,
    RUN_FREE_B = 2'b11
  } runmode_e;
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int CK_W = 3,
  parameter int HS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CK_W-1:0] ck_sel,
  input  logic [HS_W-1:0] hs_sel,
  input  logic            restart,
  output logic            tick
);
  localparam int CK_SHIFT_MAX = (2 ** CK_W) - 1;
  localparam int HS_MUL_MAX   = 2 * ((2 ** HS_W) - 1);
  localparam int PRE_W        = CK_SHIFT_MAX + $clog2(HS_MUL_MAX + 1);

  logic [PRE_W-1:0] first_div;
  logic [PRE_W-1:0] second_div;
  logic [PRE_W-1:0] div_total;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    first_div  = PRE_W'(1) << ck_sel;
    second_div = (hs_sel == '0) ? PRE_W'(1) : PRE_W'({hs_sel, 1'b0});
    div_total  = first_div * second_div;
    tick       = (pre_q == div_total - 1'b1);
    if (restart || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/ptb_period.sv
module ptb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_prd,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             immediate,
  input  logic             land_zero,
  output logic [CNT_W-1:0] prd_act
);
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] stage_q, stage_d;
  logic             act_en, stage_en;

  always_comb begin
    act_d    = act_q;
    stage_d  = stage_q;
    act_en   = 1'b0;
    stage_en = 1'b0;
    if (immediate) begin
      if (wr_prd) begin
        act_d  = wr_val;
        act_en = 1'b1;
      end
    end else begin
      if (land_zero) begin
        act_d  = stage_q;
        act_en = 1'b1;
      end
      if (wr_prd) begin
        stage_d  = wr_val;
        stage_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      stage_q <= '0;
    end else begin
      if (act_en)   act_q   <= act_d;
      if (stage_en) stage_q <= stage_d;
    end
  end

  assign prd_act = act_q;
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmode_e           mode,
  input  runmode_e         run,
  input  logic [CNT_W-1:0] prd,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             zero_stb,
  output logic             prd_stb,
  output logic             land_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             dir_q, dir_nxt;
  logic             zs_q, ps_q;
  logic             run_ok, step, go_up;

  always_comb begin
    run_ok  = (run == RUN_FREE_A) || (run == RUN_FREE_B) ||
              ((run == RUN_ENDCYC) && (cnt_q != '0));
    step    = tick && run_ok && (mode != CM_HOLD);
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    go_up   = 1'b0;
    case (mode)
      CM_UP: begin
        cnt_nxt = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
        dir_nxt = 1'b1;
      end
      CM_DOWN: begin
        cnt_nxt = (cnt_q == '0) ? prd : cnt_q - 1'b1;
        dir_nxt = 1'b0;
      end
      CM_UPDN: begin
        go_up   = dir_q ? (cnt_q < prd) : ((cnt_q == '0) && (prd != '0));
        cnt_nxt = go_up ? cnt_q + 1'b1 : ((cnt_q == '0) ? '0 : cnt_q - 1'b1);
        dir_nxt = go_up;
      end
      default: begin
        cnt_nxt = cnt_q;
        dir_nxt = dir_q;
      end
    endcase
    land_zero = step && (cnt_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      zs_q  <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      if (step) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
      zs_q <= land_zero;
      ps_q <= step && (cnt_nxt == prd);
    end
  end

  assign cnt      = cnt_q;
  assign dir_up   = dir_q;
  assign zero_stb = zs_q;
  assign prd_stb  = ps_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int              ADDR_W   = 5,
  parameter int              CNT_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 5'h00,
  parameter logic [ADDR_W-1:0] PRD_OFF  = 5'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              dir_up,
  output logic              zero_stb,
  output logic              prd_stb
);
  localparam int CK_W = DIV_MSB - CK_LSB + 1;
  localparam int HS_W = CK_LSB - HS_LSB;

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, wr_prd, div_restart;
  logic              tick, land_zero;
  logic [CNT_W-1:0]  prd_act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    wr_ctrl     = wr_en && (wr_addr == CTRL_OFF);
    wr_prd      = wr_en && (wr_addr == PRD_OFF);
    div_restart = wr_ctrl && (wr_data[DIV_MSB:HS_LSB] != ctrl_q[DIV_MSB:HS_LSB]);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_data;
    end
  end

  ptb_prescaler #(.CK_W(CK_W), .HS_W(HS_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ck_sel  (ctrl_q[DIV_MSB:CK_LSB]),
    .hs_sel  (ctrl_q[CK_LSB-1:HS_LSB]),
    .restart (div_restart),
    .tick    (tick)
  );

  ptb_period #(.CNT_W(CNT_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_prd    (wr_prd),
    .wr_val    (wr_data[CNT_W-1:0]),
    .immediate (ctrl_q[PLD_BIT]),
    .land_zero (land_zero),
    .prd_act   (prd_act)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mode      (cmode_e'(ctrl_q[MODE_LSB+1:MODE_LSB])),
    .run       (runmode_e'(ctrl_q[RUN_LSB+1:RUN_LSB])),
    .prd       (prd_act),
    .tick      (tick),
    .cnt       (cnt_out),
    .dir_up    (dir_up),
    .zero_stb  (zero_stb),
    .prd_stb   (prd_stb),
    .land_zero (land_zero)
  );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
  parameter int                ADDR_W   = 5,
  parameter int                CNT_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 5'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       ctrl,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  cnt,
  input logic              zero_stb
);
  logic ctrl_write;
  assign ctrl_write = wr_en && (wr_addr == CTRL_OFF);

  // R10
  zero_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_stb |-> (cnt == '0));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[15:14] == 2'b00) && !ctrl_write) |=> $stable(cnt));

  // R8
  endcyc_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[15:14] == 2'b01) && (cnt == '0) && !ctrl_write) |=> (cnt == '0));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[1:0] == 2'b11) && !ctrl_write) |=> $stable(cnt));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[1:0] == 2'b00) && !ctrl_write) |=>
      ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0)));
endmodule

bind pwm_timebase ptb_checker #(
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .CTRL_OFF (CTRL_OFF)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .ctrl     (ctrl_q),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .cnt      (cnt_out),
  .zero_stb (zero_stb)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_PRD  = 5'h0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_out;
  logic        dir_up, zero_stb, prd_stb;

  always #10 clk = ~clk;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_out(cnt_out), .dir_up(dir_up),
    .zero_stb(zero_stb), .prd_stb(prd_stb)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag = "R1";
  bit    cmp_on = 1'b0;

  // reference state
  logic [15:0] m_ctrl, m_act, m_sh, m_cnt;
  int unsigned m_pre;
  logic        m_dir, m_z, m_p;

  function automatic int unsigned div_of(input logic [15:0] c);
    int unsigned h;
    h = (c[9:7] == 3'd0) ? 1 : 2 * int'(c[9:7]);
    return (32'd1 << c[12:10]) * h;
  endfunction

  function automatic logic [16:0] next_of(input logic [1:0] md, input logic [15:0] c,
                                          input logic d, input logic [15:0] p);
    case (md)
      2'b00: return {1'b1, (c >= p) ? 16'd0 : c + 16'd1};
      2'b01: return {1'b0, (c == 16'd0) ? p : c - 16'd1};
      2'b10: begin
        if (d) begin
          if (c < p) return {1'b1, c + 16'd1};
          return {1'b0, (c == 16'd0) ? 16'd0 : c - 16'd1};
        end
        if (c == 16'd0 && p != 16'd0) return {1'b1, 16'd1};
        return {1'b0, (c == 16'd0) ? 16'd0 : c - 16'd1};
      end
      default: return {d, c};
    endcase
  endfunction

  logic        r_tick, r_run, r_step, r_wc, r_wp;
  logic [16:0] r_nx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_act <= '0; m_sh <= '0; m_cnt <= '0;
      m_pre <= 0; m_dir <= 1'b1; m_z <= 1'b0; m_p <= 1'b0;
    end else begin
      r_tick = (m_pre == div_of(m_ctrl) - 1);
      r_run  = m_ctrl[15] || (m_ctrl[15:14] == 2'b01 && m_cnt != 16'd0);
      r_step = r_tick && r_run && (m_ctrl[1:0] != 2'b11);
      r_nx   = next_of(m_ctrl[1:0], m_cnt, m_dir, m_act);
      r_wc   = wr_en && wr_addr == A_CTRL;
      r_wp   = wr_en && wr_addr == A_PRD;
      m_z <= r_step && r_nx[15:0] == 16'd0;
      m_p <= r_step && r_nx[15:0] == m_act;
      if (r_step) begin m_cnt <= r_nx[15:0]; m_dir <= r_nx[16]; end
      if (m_ctrl[3]) begin
        if (r_wp) m_act <= wr_data;
      end else begin
        if (r_step && r_nx[15:0] == 16'd0) m_act <= m_sh;
        if (r_wp) m_sh <= wr_data;
      end
      if (r_wc && wr_data[12:7] != m_ctrl[12:7]) m_pre <= 0;
      else if (r_tick) m_pre <= 0;
      else m_pre <= m_pre + 1;
      if (r_wc) m_ctrl <= wr_data;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string rq, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(cnt_out, m_cnt, tag, "count");
      check({15'd0, dir_up}, {15'd0, m_dir}, "R6", "dir_up");
      check({15'd0, zero_stb}, {15'd0, m_z}, "R10", "zero_stb");
      check({15'd0, prd_stb}, {15'd0, m_p}, "R10", "prd_stb");
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_change(output int cyc);
    logic [15:0] v;
    v = cnt_out; cyc = 0;
    do begin @(negedge clk); cyc++; end while (cnt_out == v && cyc < 5000);
  endtask

  task automatic wait_zero();
    int k = 0;
    do begin @(negedge clk); k++; end while (!zero_stb && k < 5000);
  endtask

  task automatic wait_prd();
    int k = 0;
    do begin @(negedge clk); k++; end while (!prd_stb && k < 5000);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c;
    logic [15:0] v;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    // R1 reset values
    check(cnt_out, 16'd0, "R1", "reset count");
    check({15'd0, dir_up}, 16'd1, "R1", "reset dir");
    check({14'd0, zero_stb, prd_stb}, 16'd0, "R1", "reset strobes");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R2: divider 2*2 = 4, up mode, immediate period load
    tag = "R4";
    wr(A_CTRL, 16'hC000 | 16'h0008 | (16'd1 << 10) | (16'd1 << 7));
    wr(A_PRD, 16'd10);
    wait_change(c);
    wait_change(c);
    check(16'(c), 16'd4, "R2", "cycles between steps");

    // R3: divider change to 2 restarts prescale count
    wr(A_CTRL, 16'hC008 | (16'd1 << 10));
    v = cnt_out;
    @(negedge clk);
    check(cnt_out, v, "R3", "no step one cycle after restart");
    @(negedge clk);
    check(cnt_out, (v >= 16'd10) ? 16'd0 : v + 16'd1, "R3", "step two cycles after restart");

    // R1: unmapped address has no effect
    wr(5'h04, 16'h0000);
    wr(5'h0B, 16'h0003);
    v = cnt_out;
    repeat (3) @(negedge clk);
    check({15'd0, cnt_out != v}, 16'd1, "R1", "still counting after unmapped writes");

    // R9: staged period takes effect at zero
    tag = "R9";
    wr(A_CTRL, 16'hC000);
    wr(A_PRD, 16'd10);
    wait_zero();
    wr(A_PRD, 16'd5);
    wait_prd();
    check(cnt_out, 16'd10, "R9", "old period until zero");
    wait_prd();
    check(cnt_out, 16'd5, "R9", "staged period after zero");

    // R5: down mode
    tag = "R5";
    wr(A_CTRL, 16'hC009);
    wait_zero();
    @(negedge clk);
    check(cnt_out, 16'd5, "R5", "down reload from zero");

    // R6: up-down mode
    tag = "R6";
    wr(A_CTRL, 16'hC00A);
    wait_prd();
    @(negedge clk);
    check(cnt_out, 16'd4, "R6", "reverse at period");
    check({15'd0, dir_up}, 16'd0, "R6", "direction down after peak");

    // R7: freeze
    tag = "R7";
    wr(A_CTRL, 16'hC00B);
    v = cnt_out;
    repeat (10) @(negedge clk);
    check(cnt_out, v, "R7", "frozen count");

    // R8: finish cycle then rest; then halt
    tag = "R8";
    wr(A_CTRL, 16'h4008);
    c = 0;
    while (cnt_out != 16'd0 && c < 50) begin @(negedge clk); c++; end
    check(cnt_out, 16'd0, "R8", "reached zero");
    repeat (15) @(negedge clk);
    check(cnt_out, 16'd0, "R8", "rests at zero");
    wr(A_CTRL, 16'hC008);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 16'h0008);
    v = cnt_out;
    repeat (10) @(negedge clk);
    check(cnt_out, v, "R8", "halt holds count");

    // R10: period 0 in up mode strobes every step
    tag = "R10";
    wr(A_CTRL, 16'hC008);
    wr(A_PRD, 16'd0);
    repeat (2) @(negedge clk);
    check({14'd0, zero_stb, prd_stb}, 16'd3, "R10", "both strobes at period zero");

    // randomized mix
    for (int i = 0; i < 200; i++) begin
      int sel = $urandom % 4;
      if (sel < 2) begin
        logic [1:0] md  = 2'($urandom % 4);
        logic [1:0] rn  = 2'($urandom % 4);
        logic       im  = 1'($urandom % 2);
        logic [2:0] ck  = 3'($urandom % 2);
        logic [2:0] hs  = 3'($urandom % 3);
        if (rn == 2'b00 && ($urandom % 2) == 0) rn = 2'b11;
        case (md)
          2'b00: tag = "R4";
          2'b01: tag = "R5";
          2'b10: tag = "R6";
          default: tag = "R7";
        endcase
        wr(A_CTRL, {rn, 1'b0, ck, hs, 3'b000, im, 1'b0, md});
      end else if (sel == 2) begin
        wr(A_PRD, 16'($urandom % 31));
      end else begin
        wr(5'($urandom % 2 == 0 ? 5'h02 : 5'h1F), 16'($urandom));
      end
      repeat ($urandom % 40) @(negedge clk);
    end

    cmp_on = 1'b0;
    finish_run();
  end
endmodule